// File: doc/BRIEF.md
# Auxiliary Packet Arrival and Change Flags

This block keeps two flag bytes for a video receiver's control space. One bit
position is given to each of seven auxiliary packet kinds. A packet parser
upstream pulses a "seen" strobe each time a packet of a kind arrives. It pulses
a "changed" strobe when that packet's payload differs from the previous one.
The arrival byte remembers every kind that has turned up. Only reset or a
loss-of-clock indication empties it.

The change byte is meant to be polled by firmware. It can be read at several
aliased addresses, and every alias returns the same contents. A read through
any alias hands back the flags that were held and then empties all seven flags
on the same clock. The next poll therefore only reports changes that came in
after the last one. Reads use a simple strobe and address. Read data is
registered and appears one clock after the strobe.

Top module: `pkt_flag_regs`

## Requirements
- R1: While reset is asserted (rst_n low), the arrival byte, the change byte and the read data all hold 0x00.
- R2: Strobe bit i drives flag bit i in both bytes. Bit 0 is the AVI infoframe, bit 1 the audio infoframe, bit 2 the source-product infoframe, bit 3 the MPEG source infoframe, bit 4 the audio content protection packet, bit 5 the first ISRC packet and bit 6 the second ISRC packet.
- R3: An arrival flag stays set once its seen strobe has pulsed. It is cleared only by reset or by clk_lost_i. When clk_lost_i and a seen strobe come in the same cycle, the byte reads 0x00 afterwards.
- R4: A change flag sets on the clock after its change strobe. It stays set until a clearing read, and reads 0x00 when nothing has changed.
- R5: The change byte is mirrored at NUM_ALIAS addresses, NEW_BASE + k*ALIAS_STRIDE (0x20, 0x30, 0x40, 0x50 by default). A read at any of them returns identical contents.
- R6: A read strobe at any alias returns, one clock later on rd_data_o, the change byte as it stood before the read. On that same clock all seven change flags go to zero.
- R7: A change strobe that lands in the same cycle as a clearing read leaves its flag set after the clear.
- R8: Bit 7 of the arrival byte, the change byte and the read data is always 0.
- R9: A read at DET_ADDR (0x10 by default) returns the arrival byte. A read at any unmapped address returns 0x00. Neither of these reads alters the change byte.
- R10: rd_data_o keeps its last value in every cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_seen_i | input | 7 | Per-kind packet arrival strobes |
| pkt_chg_i | input | 7 | Per-kind payload change strobes |
| clk_lost_i | input | 1 | Loss-of-clock indication; empties the arrival byte |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 8 | Read address |
| rd_data_o | output | 8 | Registered read data |
| det_byte_o | output | 8 | Current arrival byte |
| new_byte_o | output | 8 | Current change byte |

## Verification
The assertions assume that the strobes are single-cycle, synchronous levels sampled on the rising edge. They also assume that the address is stable whenever the read strobe is high. They assume reset is held for at least one edge, so that the first post-reset comparison against the previous cycle sees reset values. The bench drives every input on the falling edge, holds each strobe for exactly one cycle and returns it to zero, and keeps reset low for several cycles before the first scenario.

// File: rtl/pkt_flag_pkg.sv
package pkt_flag_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DET  = 2'd1,
    SEL_NEW  = 2'd2
  } rd_sel_e;

  // Arrival address takes priority if a parameter set ever overlaps the two.
  function automatic rd_sel_e pick_sel(input logic det_hit, input logic new_hit);
    if (det_hit)      return SEL_DET;
    else if (new_hit) return SEL_NEW;
    else              return SEL_NONE;
  endfunction

  // Next state of a clear-on-read flag: a new set survives the clear.
  function automatic logic cor_next(input logic cur, input logic set, input logic clr);
    return (cur & ~clr) | set;
  endfunction

  // Next state of a sticky flag: the clear beats a coincident set.
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return clr ? 1'b0 : (cur | set);
  endfunction

endpackage

// File: rtl/pkt_addr_decode.sv
module pkt_addr_decode
  import pkt_flag_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DET_ADDR    = 'h10,
  parameter int NEW_BASE    = 'h20,
  parameter int ALIAS_STRIDE = 'h10,
  parameter int NUM_ALIAS   = 4
) (
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output rd_sel_e           sel_o,
  output logic              clr_evt_o
);

  logic [NUM_ALIAS-1:0] alias_hit;
  logic                 det_hit;

  for (genvar k = 0; k < NUM_ALIAS; k++) begin : g_alias
    localparam logic [ADDR_W-1:0] ALIAS_ADDR = ADDR_W'(NEW_BASE + k * ALIAS_STRIDE);
    assign alias_hit[k] = (rd_addr_i == ALIAS_ADDR);
  end

  assign det_hit   = (rd_addr_i == ADDR_W'(DET_ADDR));
  assign sel_o     = pick_sel(det_hit, |alias_hit);
  assign clr_evt_o = rd_en_i & (sel_o == SEL_NEW);

endmodule

// File: rtl/pkt_flag_bank.sv
module pkt_flag_bank
  import pkt_flag_pkg::*;
#(
  parameter int NUM_TYPES     = 7,
  parameter bit CLEAR_ON_READ = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_TYPES-1:0] set_i,
  input  logic                 clr_i,
  output logic [NUM_TYPES-1:0] flags_o
);

  for (genvar b = 0; b < NUM_TYPES; b++) begin : g_bit
    logic nxt;
    if (CLEAR_ON_READ) begin : g_cor
      assign nxt = cor_next(flags_o[b], set_i[b], clr_i);
    end else begin : g_sticky
      assign nxt = sticky_next(flags_o[b], set_i[b], clr_i);
    end

    always_ff @(posedge clk) begin
      if (!rst_n) flags_o[b] <= 1'b0;
      else        flags_o[b] <= nxt;
    end
  end

endmodule

// File: rtl/pkt_read_port.sv
module pkt_read_port
  import pkt_flag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en_i,
  input  rd_sel_e           sel_i,
  input  logic [DATA_W-1:0] det_i,
  input  logic [DATA_W-1:0] new_i,
  output logic [DATA_W-1:0] rd_data_o
);

  logic [DATA_W-1:0] mux_val;

  always_comb begin
    unique case (sel_i)
      SEL_DET: mux_val = det_i;
      SEL_NEW: mux_val = new_i;
      default: mux_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= mux_val;
  end

endmodule

// File: rtl/pkt_flag_regs.sv
module pkt_flag_regs
  import pkt_flag_pkg::*;
#(
  parameter int NUM_TYPES    = 7,
  parameter int DATA_W       = 8,
  parameter int ADDR_W       = 8,
  parameter int DET_ADDR     = 'h10,
  parameter int NEW_BASE     = 'h20,
  parameter int ALIAS_STRIDE = 'h10,
  parameter int NUM_ALIAS    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_TYPES-1:0] pkt_seen_i,
  input  logic [NUM_TYPES-1:0] pkt_chg_i,
  input  logic                 clk_lost_i,
  input  logic                 rd_en_i,
  input  logic [ADDR_W-1:0]    rd_addr_i,
  output logic [DATA_W-1:0]    rd_data_o,
  output logic [DATA_W-1:0]    det_byte_o,
  output logic [DATA_W-1:0]    new_byte_o
);

  localparam int PAD_W = DATA_W - NUM_TYPES;

  rd_sel_e              rd_sel;
  logic                 clr_evt;
  logic [NUM_TYPES-1:0] det_flags;
  logic [NUM_TYPES-1:0] new_flags;

  pkt_addr_decode #(
    .ADDR_W(ADDR_W), .DET_ADDR(DET_ADDR), .NEW_BASE(NEW_BASE),
    .ALIAS_STRIDE(ALIAS_STRIDE), .NUM_ALIAS(NUM_ALIAS)
  ) u_dec (
    .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
    .sel_o(rd_sel), .clr_evt_o(clr_evt)
  );

  pkt_flag_bank #(.NUM_TYPES(NUM_TYPES), .CLEAR_ON_READ(1'b0)) u_det (
    .clk(clk), .rst_n(rst_n), .set_i(pkt_seen_i), .clr_i(clk_lost_i),
    .flags_o(det_flags)
  );

  pkt_flag_bank #(.NUM_TYPES(NUM_TYPES), .CLEAR_ON_READ(1'b1)) u_new (
    .clk(clk), .rst_n(rst_n), .set_i(pkt_chg_i), .clr_i(clr_evt),
    .flags_o(new_flags)
  );

  assign det_byte_o = {{PAD_W{1'b0}}, det_flags};
  assign new_byte_o = {{PAD_W{1'b0}}, new_flags};

  pkt_read_port #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en_i(rd_en_i), .sel_i(rd_sel),
    .det_i(det_byte_o), .new_i(new_byte_o), .rd_data_o(rd_data_o)
  );

endmodule

// File: rtl/pkt_flag_chk.sv
module pkt_flag_chk #(
  parameter int NUM_TYPES = 7,
  parameter int DATA_W    = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_TYPES-1:0] pkt_seen_i,
  input logic [NUM_TYPES-1:0] pkt_chg_i,
  input logic                 clk_lost_i,
  input logic                 rd_en_i,
  input logic                 clr_evt,
  input logic [DATA_W-1:0]    rd_data_o,
  input logic [DATA_W-1:0]    det_byte_o,
  input logic [DATA_W-1:0]    new_byte_o
);

  // R3: without loss of clock, no arrival flag ever drops
  assert_det_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_lost_i |=> ((det_byte_o | $past(det_byte_o)) == det_byte_o));

  assert_det_loss_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clk_lost_i |=> (det_byte_o == '0));

  // R2: a seen strobe shows up in the matching arrival bit
  assert_det_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_lost_i && pkt_seen_i != '0) |=>
      ((det_byte_o[NUM_TYPES-1:0] & $past(pkt_seen_i)) == $past(pkt_seen_i)));

  // R7: a change strobe is never lost, even with a clearing read
  assert_chg_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_chg_i != '0) |=>
      ((new_byte_o[NUM_TYPES-1:0] & $past(pkt_chg_i)) == $past(pkt_chg_i)));

  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && pkt_chg_i == '0) |=> (new_byte_o == '0));

  assert_read_old_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> (rd_data_o == $past(new_byte_o)));

  // R9: reads elsewhere leave the change flags alone
  assert_no_spurious_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_evt |=> ((new_byte_o | $past(new_byte_o)) == new_byte_o));

  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rd_data_o));

  assert_top_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (det_byte_o[DATA_W-1] == 1'b0) && (new_byte_o[DATA_W-1] == 1'b0) &&
    (rd_data_o[DATA_W-1] == 1'b0));

endmodule

bind pkt_flag_regs pkt_flag_chk #(.NUM_TYPES(NUM_TYPES), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pkt_seen_i(pkt_seen_i), .pkt_chg_i(pkt_chg_i),
  .clk_lost_i(clk_lost_i), .rd_en_i(rd_en_i), .clr_evt(clr_evt),
  .rd_data_o(rd_data_o), .det_byte_o(det_byte_o), .new_byte_o(new_byte_o)
);

// File: tb/pkt_flag_regs_test.sv
module pkt_flag_regs_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] seen = '0;
  logic [6:0] chg = '0;
  logic       lost = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_addr = '0;
  logic [7:0] rd_data, det_b, new_b;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  localparam logic [7:0] A_DET = 8'h10;
  localparam logic [7:0] A_NEW0 = 8'h20;
  localparam logic [7:0] A_NEW1 = 8'h30;
  localparam logic [7:0] A_NEW3 = 8'h50;

  always #2 clk = ~clk;

  pkt_flag_regs uut (
    .clk(clk), .rst_n(rst_n), .pkt_seen_i(seen), .pkt_chg_i(chg),
    .clk_lost_i(lost), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .det_byte_o(det_b), .new_byte_o(new_b)
  );

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  // Drive one cycle of inputs at the falling edge, return at the next one.
  task automatic step(input logic [6:0] s, input logic [6:0] c, input logic l,
                      input logic r, input logic [7:0] a);
    seen = s; chg = c; lost = l; rd_en = r; rd_addr = a;
    @(negedge clk);
    seen = '0; chg = '0; lost = 1'b0; rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step('0, '0, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic t_reset;
    check("R1", "det in reset", det_b, 8'h00);
    check("R1", "new in reset", new_b, 8'h00);
    check("R1", "rd in reset", rd_data, 8'h00);
  endtask

  task automatic t_mapping;
    step('0, 7'h08, 1'b0, 1'b0, 8'h00);           // MPEG source change
    check("R2", "change bit 3", new_b, 8'h08);
    check("R4", "change held", new_b, 8'h08);
    step(7'h20, '0, 1'b0, 1'b0, 8'h00);           // first ISRC arrival
    check("R2", "arrival bit 5", det_b, 8'h20);
    idle(3);
    check("R4", "change sticky", new_b, 8'h08);
    step('0, '0, 1'b0, 1'b1, A_NEW0);
    check("R4", "change cleared", new_b, 8'h00);
  endtask

  task automatic t_sticky_det;
    step(7'h01, '0, 1'b0, 1'b0, 8'h00);
    idle(4);
    check("R3", "arrival sticky", det_b, 8'h21);
    step('0, '0, 1'b0, 1'b1, A_DET);
    check("R9", "arrival read", rd_data, 8'h21);
    check("R3", "arrival after read", det_b, 8'h21);
    step('0, '0, 1'b1, 1'b0, 8'h00);
    check("R3", "loss clears", det_b, 8'h00);
    step(7'h44, '0, 1'b1, 1'b0, 8'h00);
    check("R3", "loss beats seen", det_b, 8'h00);
  endtask

  task automatic t_aliases;
    for (int k = 0; k < 4; k++) begin
      logic [7:0] a;
      a = 8'h20 + 8'(k * 16);
      step('0, 7'h55 ^ 7'(k), 1'b0, 1'b0, 8'h00);
      step('0, '0, 1'b0, 1'b1, a);
      check("R5", $sformatf("alias %02h data", a), rd_data, 8'h55 ^ 8'(k));
      check("R6", $sformatf("alias %02h clears", a), new_b, 8'h00);
    end
  endtask

  task automatic t_collide;
    step('0, 7'h11, 1'b0, 1'b0, 8'h00);
    step('0, 7'h40, 1'b0, 1'b1, A_NEW1);
    check("R6", "pre-clear value", rd_data, 8'h11);
    check("R7", "coincident change kept", new_b, 8'h40);
    step('0, '0, 1'b0, 1'b1, A_NEW3);
    check("R7", "kept flag readable", rd_data, 8'h40);
    check("R6", "then cleared", new_b, 8'h00);
  endtask

  task automatic t_nonclear;
    step(7'h7F, 7'h7F, 1'b0, 1'b0, 8'h00);
    check("R8", "det top bit", det_b, 8'h7F);
    check("R8", "new top bit", new_b, 8'h7F);
    step('0, '0, 1'b0, 1'b1, A_DET);
    check("R9", "det addr data", rd_data, 8'h7F);
    check("R9", "det read keeps change", new_b, 8'h7F);
    step('0, '0, 1'b0, 1'b1, 8'h21);
    check("R9", "unmapped data", rd_data, 8'h00);
    check("R9", "unmapped keeps change", new_b, 8'h7F);
    step('0, '0, 1'b0, 1'b1, A_NEW0);
    check("R8", "read top bit", rd_data, 8'h7F);
  endtask

  task automatic t_hold;
    step('0, 7'h03, 1'b0, 1'b0, 8'h00);
    idle(3);
    check("R10", "rd held w/o strobe", rd_data, 8'h7F);
    step('0, '0, 1'b0, 1'b0, A_NEW0);             // address only, no strobe
    check("R10", "no strobe no clear", new_b, 8'h03);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_mapping();
    t_sticky_det();
    t_aliases();
    t_collide();
    t_nonclear();
    t_hold();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #40000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL ALL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule